// File: doc/BRIEF.md
# Configurable Event Interrupt Generator

This block turns eight condition inputs into one interrupt pin. Each source has its own trigger code, which selects rising edge, falling edge or level. An edge trigger sets a sticky status bit. Software clears that bit by writing a one to it. A level trigger makes the status bit track the condition. A mask register decides which status bits can reach the pin. A separate polarity field then decides how the pin is driven: active-high, active-low, or drive-low-only through an output enable.

Software reaches the registers over a small synchronous register port. Writes happen on the clock edge when `reg_we` is high. Reads are combinational from `reg_addr`. Each source's trigger code is split across two registers. The upper register holds code bit 1 and the lower register holds code bit 0, both at the source's own bit position. Bit positions 6 and 2 are reserved sources. They never hold status.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, so every source is in rising-edge mode, the mask is clear and the polarity is active-high. `irq_o`=0 and `irq_oe_o`=1.
- R2: The trigger code of source i is {mode-upper[i], mode-lower[i]}. The upper register is at address 2 and the lower register is at address 3.
- R3: Code 00 (rising) sets status bit i when condition i goes 0→1. The bit becomes visible on the second rising clock edge after the input changes.
- R4: Code 01 (falling) sets status bit i when condition i goes 1→0, with the same two-edge latency.
- R5: Code 10 (level) makes status bit i equal condition i as it was sampled one edge earlier. Writing 1 to that bit has no effect.
- R6: Code 11 behaves exactly like level mode and never latches an edge.
- R7: An edge-mode status bit stays set until a write of 1 to that bit at address 0. Writing 0 leaves it unchanged.
- R8: If a new edge and a write-1-to-clear reach the same bit on the same edge, the bit stays set.
- R9: Status bits 6 and 2 always read 0 and never drive the pin, whatever their conditions do.
- R10: The pin is asserted exactly when status AND mask is nonzero. The mask is at address 1.
- R11: The polarity field is at address 4, bits 1:0. Code 00 gives `irq_o`=active with `irq_oe_o`=1. Code 01 gives `irq_o`=!active with `irq_oe_o`=1. Code 10 gives `irq_o`=0 with `irq_oe_o`=active. Code 11 behaves as 00.
- R12: Address 0 reads status. Address 4 returns the polarity field in bits 1:0 with zeros above. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_i | input | 8 | Condition inputs, one per source |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin drive enable |

## Verification
Two events can land on the same edge: a newly detected edge and a software write-1-to-clear aimed at the same status bit. The bench provokes this by raising a condition on one cycle. On the very next cycle, while that edge is being evaluated, it writes the clear. A behavioural model predicts that the set wins, and the bench compares the status read-back and the pin against that model. The same per-cycle model also judges the pin through mode changes, mask changes and polarity changes.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

   typedef enum logic [1:0] {
      TRIG_RISE  = 2'b00,
      TRIG_FALL  = 2'b01,
      TRIG_LEVEL = 2'b10,
      TRIG_RSVD  = 2'b11
   } trig_e;

   typedef enum logic [1:0] {
      PIN_HIGH  = 2'b00,
      PIN_LOW   = 2'b01,
      PIN_DRAIN = 2'b10,
      PIN_RSVD  = 2'b11
   } pin_e;

   localparam int unsigned A_STATUS  = 0;
   localparam int unsigned A_MASK    = 1;
   localparam int unsigned A_MODE_HI = 2;
   localparam int unsigned A_MODE_LO = 3;
   localparam int unsigned A_POL     = 4;
   localparam int unsigned A_COUNT   = 5;

endpackage

// File: rtl/evt_cond_track.sv
module evt_cond_track #(
   parameter int unsigned NSRC = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] cond_i,
   output logic [NSRC-1:0] cond_q_o,
   output logic [NSRC-1:0] rise_o,
   output logic [NSRC-1:0] fall_o
);
   logic [NSRC-1:0] cur_q;
   logic [NSRC-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         prev_q <= '0;
      end else begin
         cur_q  <= cond_i;
         prev_q <= cur_q;
      end
   end

   assign cond_q_o = cur_q;
   assign rise_o   = cur_q & ~prev_q;
   assign fall_o   = ~cur_q & prev_q;
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank
   import evt_irq_pkg::*;
#(
   parameter int unsigned     NSRC     = 8,
   parameter logic [NSRC-1:0] RSVD_POS = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] mode_hi_i,
   input  logic [NSRC-1:0] mode_lo_i,
   input  logic [NSRC-1:0] cond_q_i,
   input  logic [NSRC-1:0] rise_i,
   input  logic [NSRC-1:0] fall_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] sts_o
);
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (RSVD_POS[i]) begin : g_rsvd
         assign sts_o[i] = 1'b0;
      end else begin : g_live
         trig_e code;
         logic  sts_q;
         assign code = trig_e'({mode_hi_i[i], mode_lo_i[i]});

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sts_q <= 1'b0;
            end else begin
               case (code)
                  TRIG_RISE: sts_q <= rise_i[i] | (sts_q & ~clr_i[i]);
                  TRIG_FALL: sts_q <= fall_i[i] | (sts_q & ~clr_i[i]);
                  default:   sts_q <= cond_q_i[i];
               endcase
            end
         end
         assign sts_o[i] = sts_q;
      end
   end
endmodule

// File: rtl/evt_pin_drive.sv
module evt_pin_drive
   import evt_irq_pkg::*;
(
   input  logic [1:0] pol_i,
   input  logic       active_i,
   output logic       irq_o,
   output logic       irq_oe_o
);
   always_comb begin
      case (pin_e'(pol_i))
         PIN_LOW: begin
            irq_o    = ~active_i;
            irq_oe_o = 1'b1;
         end
         PIN_DRAIN: begin
            irq_o    = 1'b0;
            irq_oe_o = active_i;
         end
         default: begin
            irq_o    = active_i;
            irq_oe_o = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
   import evt_irq_pkg::*;
#(
   parameter int unsigned     NSRC     = 8,
   parameter int unsigned     DATA_W   = 8,
   parameter int unsigned     ADDR_W   = 3,
   parameter logic [NSRC-1:0] RSVD_POS = 8'b0100_0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   cond_i,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o,
   output logic              irq_oe_o
);
   localparam int unsigned POL_W = 2;

   if (NSRC != DATA_W) begin : g_chk_width
      $error("evt_irq_ctrl: NSRC must equal DATA_W");
   end
   if (DATA_W <= POL_W) begin : g_chk_data
      $error("evt_irq_ctrl: DATA_W too small for polarity field");
   end
   if ((1 << ADDR_W) < A_COUNT) begin : g_chk_addr
      $error("evt_irq_ctrl: ADDR_W too small for register map");
   end

   logic [NSRC-1:0]  mask_q;
   logic [NSRC-1:0]  mode_hi_q;
   logic [NSRC-1:0]  mode_lo_q;
   logic [POL_W-1:0] pol_q;
   logic [NSRC-1:0]  cond_q;
   logic [NSRC-1:0]  rise;
   logic [NSRC-1:0]  fall;
   logic [NSRC-1:0]  clr;
   logic [NSRC-1:0]  sts;
   logic             active;

   logic wr_status, wr_mask, wr_hi, wr_lo, wr_pol;
   assign wr_status = reg_we && (reg_addr == ADDR_W'(A_STATUS));
   assign wr_mask   = reg_we && (reg_addr == ADDR_W'(A_MASK));
   assign wr_hi     = reg_we && (reg_addr == ADDR_W'(A_MODE_HI));
   assign wr_lo     = reg_we && (reg_addr == ADDR_W'(A_MODE_LO));
   assign wr_pol    = reg_we && (reg_addr == ADDR_W'(A_POL));
   assign clr       = wr_status ? reg_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         mode_hi_q <= '0;
         mode_lo_q <= '0;
         pol_q     <= '0;
      end else begin
         if (wr_mask) mask_q    <= reg_wdata;
         if (wr_hi)   mode_hi_q <= reg_wdata;
         if (wr_lo)   mode_lo_q <= reg_wdata;
         if (wr_pol)  pol_q     <= reg_wdata[POL_W-1:0];
      end
   end

   evt_cond_track #(.NSRC(NSRC)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .cond_i   (cond_i),
      .cond_q_o (cond_q),
      .rise_o   (rise),
      .fall_o   (fall)
   );

   evt_status_bank #(.NSRC(NSRC), .RSVD_POS(RSVD_POS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_hi_i (mode_hi_q),
      .mode_lo_i (mode_lo_q),
      .cond_q_i  (cond_q),
      .rise_i    (rise),
      .fall_i    (fall),
      .clr_i     (clr),
      .sts_o     (sts)
   );

   assign active = |(sts & mask_q);

   evt_pin_drive u_pin (
      .pol_i    (pol_q),
      .active_i (active),
      .irq_o    (irq_o),
      .irq_oe_o (irq_oe_o)
   );

   always_comb begin
      case (reg_addr)
         ADDR_W'(A_STATUS):  reg_rdata = sts;
         ADDR_W'(A_MASK):    reg_rdata = mask_q;
         ADDR_W'(A_MODE_HI): reg_rdata = mode_hi_q;
         ADDR_W'(A_MODE_LO): reg_rdata = mode_lo_q;
         ADDR_W'(A_POL):     reg_rdata = {{(DATA_W-POL_W){1'b0}}, pol_q};
         default:            reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
   parameter int unsigned     NSRC     = 8,
   parameter int unsigned     DATA_W   = 8,
   parameter int unsigned     ADDR_W   = 3,
   parameter logic [NSRC-1:0] RSVD_POS = 8'b0100_0100
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NSRC-1:0]   sts,
   input logic [NSRC-1:0]   mask_q,
   input logic [NSRC-1:0]   mode_hi_q,
   input logic [NSRC-1:0]   cond_q,
   input logic [1:0]        pol_q,
   input logic              irq_o,
   input logic              irq_oe_o
);
   logic [NSRC-1:0] w1c;
   logic            hit;
   assign w1c = (reg_we && reg_addr == '0) ? reg_wdata : '0;
   assign hit = |(sts & mask_q);

   // R7: edge-mode bits stay set unless cleared
   a_r7_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1 |=> (($past(sts & ~mode_hi_q & ~w1c) & ~mode_hi_q & ~sts) == '0));

   // R5 and R6: level-type bits follow sampled condition
   a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1 |=> (((sts ^ $past(cond_q)) & $past(mode_hi_q) & ~RSVD_POS) == '0));

   // R9: reserved positions read zero
   a_r9_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == '0) |-> ((reg_rdata & RSVD_POS) == '0));

   // R11: pin forms per polarity code
   a_r11_active_high: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_q == 2'b00 || pol_q == 2'b11) |-> (irq_o == hit && irq_oe_o));
   a_r11_active_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_q == 2'b01) |-> (irq_o == !hit && irq_oe_o));
   a_r11_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_q == 2'b10) |-> (!irq_o && irq_oe_o == hit));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
   .NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RSVD_POS(RSVD_POS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .sts       (sts),
   .mask_q    (mask_q),
   .mode_hi_q (mode_hi_q),
   .cond_q    (cond_q),
   .pol_q     (pol_q),
   .irq_o     (irq_o),
   .irq_oe_o  (irq_oe_o)
);

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cond_i = '0;
   logic [2:0] reg_addr = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq_o, irq_oe_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   evt_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o), .irq_oe_o(irq_oe_o)
   );

   // behavioural reference state
   localparam logic [7:0] RSVD = 8'h44;
   logic [7:0] m_cq = 0, m_cp = 0, m_sts = 0, m_mask = 0, m_hi = 0, m_lo = 0;
   logic [1:0] m_pol = 0;

   function automatic logic [7:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_sts;
         3'd1: return m_mask;
         3'd2: return m_hi;
         3'd3: return m_lo;
         3'd4: return {6'b0, m_pol};
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_pin();
      logic a;
      logic e_irq, e_oe;
      a = |(m_sts & m_mask);
      case (m_pol)
         2'd1: begin e_irq = ~a; e_oe = 1'b1; end
         2'd2: begin e_irq = 1'b0; e_oe = a; end
         default: begin e_irq = a; e_oe = 1'b1; end
      endcase
      check("R10 irq_o", {7'b0, irq_o}, {7'b0, e_irq});
      check("R11 irq_oe_o", {7'b0, irq_oe_o}, {7'b0, e_oe});
   endtask

   // one clock with the given inputs; model advances, outputs compared
   task automatic step(input logic [7:0] c, input logic [2:0] a = 3'd7,
                       input bit w = 0, input logic [7:0] d = 8'h00);
      logic [7:0] nsts, clr;
      cond_i = c; reg_addr = a; reg_we = w; reg_wdata = d;
      @(posedge clk);
      clr = (w && a == 3'd0) ? d : 8'h00;
      for (int i = 0; i < 8; i++) begin
         if (RSVD[i]) nsts[i] = 1'b0;
         else if (m_hi[i]) nsts[i] = m_cq[i];
         else if (!m_lo[i]) nsts[i] = (m_cq[i] & ~m_cp[i]) | (m_sts[i] & ~clr[i]);
         else nsts[i] = (~m_cq[i] & m_cp[i]) | (m_sts[i] & ~clr[i]);
      end
      m_sts = nsts;
      m_cp = m_cq;
      m_cq = c;
      if (w && a == 3'd1) m_mask = d;
      if (w && a == 3'd2) m_hi = d;
      if (w && a == 3'd3) m_lo = d;
      if (w && a == 3'd4) m_pol = d[1:0];
      @(negedge clk);
      reg_we = 1'b0;
      check_pin();
   endtask

   task automatic rd(input string req, input logic [2:0] a);
      reg_addr = a;
      #1;
      check(req, reg_rdata, m_read(a));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1, R12: reset values and full map
      check_pin();
      for (int a = 0; a < 8; a++) rd("R1 R12 reset read", 3'(a));

      step(8'h00, 3'd1, 1, 8'hFF);            // mask all
      // R3: rising edge on source 0
      step(8'h01);
      rd("R3 not yet", 3'd0);
      step(8'h01);
      rd("R3 latched", 3'd0);
      step(8'h00);
      step(8'h00);
      rd("R7 held after drop", 3'd0);
      step(8'h00, 3'd0, 1, 8'h00);
      rd("R7 write zero no effect", 3'd0);
      step(8'h00, 3'd0, 1, 8'h01);
      rd("R7 cleared", 3'd0);

      // R2: modes: src1 falling, src3 level, src4 reserved code
      step(8'h00, 3'd2, 1, 8'h18);
      step(8'h00, 3'd3, 1, 8'h12);
      rd("R2 upper", 3'd2);
      rd("R2 lower", 3'd3);
      // R4: falling edge on src1
      step(8'h02);
      step(8'h02);
      rd("R4 no set on rise", 3'd0);
      step(8'h00);
      step(8'h00);
      rd("R4 set on fall", 3'd0);
      step(8'h00, 3'd0, 1, 8'h02);
      rd("R4 cleared", 3'd0);

      // R5: level on src3, R6: code 11 on src4
      step(8'h18);
      step(8'h18);
      rd("R5 R6 follow high", 3'd0);
      step(8'h18, 3'd0, 1, 8'h18);
      rd("R5 W1C ignored", 3'd0);
      step(8'h00);
      step(8'h00);
      rd("R5 R6 follow low", 3'd0);
      step(8'h10);
      step(8'h00);
      step(8'h00);
      rd("R6 no edge latch", 3'd0);

      // R8: edge and clear on the same edge
      step(8'h01);
      step(8'h01, 3'd0, 1, 8'h01);
      rd("R8 set wins", 3'd0);
      step(8'h01, 3'd0, 1, 8'h01);
      rd("R8 later clear", 3'd0);
      step(8'h00);

      // R9: reserved sources toggling
      for (int k = 0; k < 4; k++) step((k % 2) ? 8'h44 : 8'h00);
      rd("R9 reserved read zero", 3'd0);
      check("R9 pin idle", {7'b0, irq_o}, 8'h00);

      // R10: mask gating
      step(8'h20);
      step(8'h20);
      step(8'h00, 3'd1, 1, 8'hDF);
      check("R10 masked off", {7'b0, irq_o}, 8'h00);
      step(8'h00, 3'd1, 1, 8'h20);
      check("R10 unmasked", {7'b0, irq_o}, 8'h01);

      // R11: polarity codes with the pin active and inactive
      for (int p = 0; p < 4; p++) begin
         step(8'h00, 3'd4, 1, 8'hFC | 8'(p));
         rd("R11 R12 pol read", 3'd4);
         step(8'h00, 3'd0, 1, 8'h20);
         step(8'h20);
         step(8'h20);
         step(8'h00);
      end
      step(8'h00, 3'd0, 1, 8'hFF);
      for (int a = 5; a < 8; a++) rd("R12 unused", 3'(a));

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule